// File: doc/BRIEF.md
# Complement-Paired Serial Number Scanner

This block locates a device serial number kept in fuse storage as a word stored next to its bitwise inverse. After a start pulse it works through candidate slot pairs, beginning at the top of the reserved range and moving down. For each pair it fetches the even-indexed word, then the odd word just above it. It stops at the first pair where the even word is the exact inverse of the odd word.

The block talks to a word-read port that has a request pulse and a completion strobe. Only one read is in flight at any time. When the scan ends, a one-cycle done pulse marks the result. The result is the serial value plus a flag that says whether a valid pair was found. When no pair matches, the serial output still holds the last even-indexed word that was read.

Top module: `serial_pair_scan`

## Requirements
- R1: The first read request of a scan addresses index 0xFE, and each later candidate pair sits 2 below the one before it.
- R2: The lowest candidate is index 2, and index 0 is never requested. A scan that finds no match issues exactly 254 reads.
- R3: For candidate i, the word at i is requested first and the word at i+1 second. `rd_addr_o` stays stable until that read's `rd_done_i`.
- R4: A pair is valid when the even word equals the bitwise inverse of the odd word. No read is issued after the first valid pair.
- R5: When a valid pair is found, `found_o` is 1 and `serial_o` equals the even word of that pair.
- R6: When no pair matches, `found_o` is 0 and `serial_o` equals the word read at index 2.
- R7: `done_o` is high for exactly one cycle, in the cycle after the `rd_done_i` of the scan's final read.
- R8: A `start_i` pulse that arrives while a scan is in progress has no effect on the read sequence or on the result.
- R9: `rd_req_o` is a single-cycle pulse, and no new request is made until the previous read has returned `rd_done_i`.
- R10: During reset, and after it is released, `rd_req_o`, `done_o`, `found_o` and `busy_o` are 0 and `serial_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts a scan; ignored while busy |
| rd_req_o | output | 1 | Single-cycle word-read request |
| rd_addr_o | output | ADDR_W | Word index of the current read |
| rd_done_i | input | 1 | Read completion strobe; rd_data_i is valid in the same cycle |
| rd_data_i | input | DATA_W | Returned word |
| busy_o | output | 1 | High while a scan is in progress |
| done_o | output | 1 | Single-cycle result strobe |
| found_o | output | 1 | A valid pair was found in the last scan |
| serial_o | output | DATA_W | Serial value from the last scan |

## Verification
The bench builds the scanner with its default parameters: 32-bit words, 12-bit indices, scan top 0xFE and floor 2. With these values the worst case, a full 127-pair scan with no match, fits easily within the cycle budget. That makes the no-match fallback and the index-0 exclusion checkable from end to end. The bench's word store answers after a latency that it varies between zero and several cycles, which exercises the waiting between reads. The scenarios place matches at the top slot, in the middle, in two places at once, and only at index 0, and also include a start pulse that arrives mid-scan.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ_LO = 3'd1,
    ST_WT_LO  = 3'd2,
    ST_REQ_HI = 3'd3,
    ST_WT_HI  = 3'd4,
    ST_FIN    = 3'd5
  } scan_state_e;
endpackage

// File: rtl/srs_index.sv
module srs_index #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TOP_IDX  = 254,
  parameter int unsigned LOW_IDX  = 2,
  parameter int unsigned STRIDE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              at_low_o
);
  localparam logic [ADDR_W-1:0] TopV  = ADDR_W'(TOP_IDX);
  localparam logic [ADDR_W-1:0] LowV  = ADDR_W'(LOW_IDX);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              idx_en;

  always_comb begin
    idx_en = ld_i | dec_i;
    idx_d  = idx_q;
    if (ld_i)       idx_d = TopV;
    else if (dec_i) idx_d = idx_q - StepV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o    = idx_q;
  assign at_low_o = (idx_q == LowV);

  // R1 / R2: the index never steps below the floor
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |=> (idx_q >= LowV));
  p_even_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i || dec_i) |=> (idx_q[0] == 1'b0));
endmodule

// File: rtl/srs_pair_eval.sv
module srs_pair_eval #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo_i,
  input  logic              clr_found_i,
  input  logic              set_found_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              match_o,
  output logic [DATA_W-1:0] lo_word_o,
  output logic              found_o
);
  logic [DATA_W-1:0] lo_q;
  logic              found_q, found_d, found_en;

  assign match_o = (lo_q == ~rd_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_q <= '0;
    else if (cap_lo_i) lo_q <= rd_data_i;
  end

  always_comb begin
    found_en = clr_found_i | set_found_i;
    found_d  = set_found_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        found_q <= 1'b0;
    else if (found_en) found_q <= found_d;
  end

  assign lo_word_o = lo_q;
  assign found_o   = found_q;

  // R5: a set flag always sits beside a word that inverts the matching odd word
  p_found_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_found_i |=> (found_q && lo_q == ~$past(rd_data_i)));
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rd_done_i,
  input  logic match_i,
  input  logic at_low_i,
  output logic ld_idx_o,
  output logic dec_idx_o,
  output logic cap_lo_o,
  output logic set_found_o,
  output logic clr_found_o,
  output logic hi_sel_o,
  output logic rd_req_o,
  output logic busy_o,
  output logic done_o
);
  scan_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    ld_idx_o    = 1'b0;
    dec_idx_o   = 1'b0;
    cap_lo_o    = 1'b0;
    set_found_o = 1'b0;
    clr_found_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        ld_idx_o    = 1'b1;
        clr_found_o = 1'b1;
        st_d        = ST_REQ_LO;
      end
      ST_REQ_LO: st_d = ST_WT_LO;
      ST_WT_LO: if (rd_done_i) begin
        cap_lo_o = 1'b1;
        st_d     = ST_REQ_HI;
      end
      ST_REQ_HI: st_d = ST_WT_HI;
      ST_WT_HI: if (rd_done_i) begin
        if (match_i) begin
          set_found_o = 1'b1;
          st_d        = ST_FIN;
        end else if (at_low_i) begin
          st_d = ST_FIN;
        end else begin
          dec_idx_o = 1'b1;
          st_d      = ST_REQ_LO;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign rd_req_o = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
  assign hi_sel_o = (st_q == ST_REQ_HI) || (st_q == ST_WT_HI);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_FIN);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  p_wait_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WT_LO || st_q == ST_WT_HI) && !rd_done_i) |=> !rd_req_o);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: rtl/serial_pair_scan.sv
module serial_pair_scan #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned TOP_IDX = 254,
  parameter int unsigned LOW_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [DATA_W-1:0] serial_o
);
  localparam int unsigned PairStride = 2;

  logic              ld_idx, dec_idx, cap_lo, set_found, clr_found, hi_sel;
  logic              match, at_low;
  logic [ADDR_W-1:0] idx;

  srs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_done_i   (rd_done_i),
    .match_i     (match),
    .at_low_i    (at_low),
    .ld_idx_o    (ld_idx),
    .dec_idx_o   (dec_idx),
    .cap_lo_o    (cap_lo),
    .set_found_o (set_found),
    .clr_found_o (clr_found),
    .hi_sel_o    (hi_sel),
    .rd_req_o    (rd_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  srs_index #(
    .ADDR_W  (ADDR_W),
    .TOP_IDX (TOP_IDX),
    .LOW_IDX (LOW_IDX),
    .STRIDE  (PairStride)
  ) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (ld_idx),
    .dec_i    (dec_idx),
    .idx_o    (idx),
    .at_low_o (at_low)
  );

  srs_pair_eval #(
    .DATA_W (DATA_W)
  ) u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_lo_i    (cap_lo),
    .clr_found_i (clr_found),
    .set_found_i (set_found),
    .rd_data_i   (rd_data_i),
    .match_o     (match),
    .lo_word_o   (serial_o),
    .found_o     (found_o)
  );

  assign rd_addr_o = {idx[ADDR_W-1:1], hi_sel};

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rd_req_o && !done_o && !rd_done_i && !$rose(busy_o)) |=> $stable(rd_addr_o));
  p_never_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o >= ADDR_W'(LOW_IDX)));
endmodule

// File: tb/serial_pair_scan_bench.sv
module serial_pair_scan_bench;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          rd_req_o, rd_done_i, busy_o, done_o, found_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i, serial_o;

  always #2 clk = ~clk;

  serial_pair_scan u_serial_pair_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_done_i(rd_done_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .serial_o(serial_o)
  );

  int checks = 0, failures = 0;
  logic [DW-1:0] mem [256];
  int  exp_q[$];
  int  lat = 0;
  logic exp_found;
  logic [DW-1:0] exp_serial;
  int  exp_reads, reads_seen, dones_seen;
  bit  pend, pend_last, done_next;
  int  pend_addr, wcnt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic fill_noise();
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + DW'(i * 7);
  endtask

  task automatic build_ref();
    exp_q.delete();
    exp_found = 1'b0;
    exp_serial = '0;
    for (int i = 254; i >= 2; i -= 2) begin
      exp_q.push_back(i);
      exp_q.push_back(i + 1);
      exp_serial = mem[i];
      if (mem[i] == ~mem[i + 1]) begin
        exp_found = 1'b1;
        break;
      end
    end
    exp_reads = exp_q.size();
  endtask

  task automatic run_scan(input int latency, input bit poke_start, input string tag);
    lat = latency;
    build_ref();
    reads_seen = 0;
    dones_seen = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_start) begin
      repeat (9) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (dones_seen == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(reads_seen == exp_reads, tag, reads_seen, exp_reads);
    chk(dones_seen == 1, "R7", dones_seen, 1);
    chk(busy_o == 1'b0, "R8", busy_o, 0);
  endtask

  // reference model and word store, evaluated at every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o || done_next) begin
        chk(done_o == done_next, "R7", done_o, done_next);
        if (done_o) begin
          dones_seen++;
          chk(found_o == exp_found, exp_found ? "R5" : "R6", found_o, exp_found);
          chk(serial_o == exp_serial, exp_found ? "R5" : "R6", serial_o, exp_serial);
        end
      end
      done_next = 1'b0;
      rd_done_i = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          rd_done_i = 1'b1;
          rd_data_i = mem[pend_addr];
          pend = 1'b0;
          if (pend_last) done_next = 1'b1;
        end else begin
          wcnt--;
          chk(rd_addr_o == AW'(pend_addr), "R3", rd_addr_o, pend_addr);
        end
      end
      if (rd_req_o) begin
        chk(!pend && !rd_done_i, "R9", pend, 0);
        reads_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", rd_addr_o, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(rd_addr_o == AW'(e), (e == 254) ? "R1" : ((e % 2) ? "R3" : "R2"), rd_addr_o, e);
          pend = 1'b1;
          pend_addr = e;
          pend_last = (exp_q.size() == 0);
          wcnt = lat;
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    rd_done_i = 1'b0;
    rd_data_i = '0;
    pend = 1'b0;
    pend_last = 1'b0;
    done_next = 1'b0;
    wcnt = 0;
    pend_addr = 0;
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(!rd_req_o && !done_o && !found_o && !busy_o && serial_o == '0, "R10", serial_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req_o && !done_o && !busy_o, "R10", busy_o, 0);

    fill_noise();
    mem[254] = 32'h1234_5678; mem[255] = ~32'h1234_5678;
    run_scan(0, 1'b0, "R4");

    fill_noise();
    mem[64] = 32'hCAFE_0042; mem[65] = ~32'hCAFE_0042;
    run_scan(2, 1'b0, "R4");

    fill_noise();
    mem[100] = 32'h0BAD_F00D; mem[101] = ~32'h0BAD_F00D;
    mem[20]  = 32'h7777_0001; mem[21]  = ~32'h7777_0001;
    run_scan(1, 1'b1, "R8");

    fill_noise();
    mem[0] = 32'hAAAA_5555; mem[1] = ~32'hAAAA_5555;
    run_scan(0, 1'b0, "R2");

    fill_noise();
    mem[2] = 32'hFFFF_0000; mem[3] = 32'hFFFF_0000;
    run_scan(3, 1'b0, "R6");

    fill_noise();
    mem[2] = 32'h00C0_FFEE; mem[3] = ~32'h00C0_FFEE;
    run_scan(0, 1'b1, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule